// File: doc/BRIEF.md
# Multi-CPU Interrupt Routing Mapper

This block takes 128 level-sensitive interrupt sources and steers them to four CPUs. Each CPU has a private register window. The window holds a mask for each of the two 64-bit banks, a 3-bit pin-select entry for every source, a read-only status word per bank and two mailbox words. Any source that is unmasked and active sets its status bit for that CPU. The CPU pin named by that source's select entry then goes high. Each CPU has five pin outputs.

Source numbers 0 to 63 sit in the high bank and 64 to 127 in the low bank. High-bank bit 0 carries no source of its own. It reports whether any low-bank status bit is set, so a handler reads the high word first and moves to the low word only when that bit is set. The upper sixteen bits of each CPU's mailbox 0 form one further source, which is used for messages between CPUs. A shared sticky latch captures pulsed events from a bridge. Those events then act as level sources for every CPU until software writes ones to the latch's clear alias.

Software reaches all registers over a single-cycle word-addressed bus. Read data is combinational. Writes take effect at the next rising clock edge.

Top module: `irqmap_router`

## Requirements
- R1: After reset every mask bit is 1, every pin-select entry is 0, both mailboxes and the bridge latch are 0, and all `cpu_pin_o` bits are 0.
- R2: Source s is at bit s of the high bank when s < 64, and at bit s-64 of the low bank otherwise. A status bit reads 1 exactly when the source is active and its mask bit is 0. A source is active when its `irq_src_i` bit is high, its bridge latch bit is set, or (for the mailbox source only) its mailbox bits are set. The status read reflects a change on `irq_src_i` in the same cycle.
- R3: High-bank status bit 0 reads as the OR of all 64 low-bank status bits, whatever mask bit 0 holds. It never drives a pin by itself.
- R4: `cpu_pin_o[c*5+k]` is high when any status bit of CPU c for a source s ≥ 1 has pin-select value k (k = 0..4). The entry keeps `reg_wdata_i[2:0]`. The values 5 to 7 drive no pin.
- R5: `reg_addr_i[9:8]` picks the CPU window. A write changes only that CPU's masks, select entries and mailboxes.
- R6: For mailboxes, writing to a set alias ORs the written ones in, and writing to a clear alias clears the bits written as 1, so writing all ones empties the mailbox. Both aliases read back the mailbox value.
- R7: When any bit of mailbox 0 in [63:48] is set, source 7 of that CPU is active.
- R8: A high `bridge_evt_i[s]` at a rising edge sets shared latch bit s, and the bit stays set until a one is written to it through a latch clear alias from any window. When an event and a clear land on the same edge, the clear wins.
- R9: Word offsets with `reg_addr_i[7]`=0 are: 0 mask-high, 1 mask-low, 2 status-high, 3 status-low, 4/5 mailbox 0/1 set, 6/7 mailbox 0/1 clear, 8/9 latch high/low, 10/11 latch high/low clear. With `reg_addr_i[7]`=1, `reg_addr_i[6:0]` selects the source's pin-select entry. Other offsets read 0. Writes to the status and latch read offsets have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_src_i | input | 128 | Level interrupt sources |
| bridge_evt_i | input | 128 | Event pulses captured by the shared sticky latch |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 10 | Word address: CPU, map-space flag, index |
| reg_wdata_i | input | 64 | Write data |
| reg_rdata_o | output | 64 | Combinational read data |
| cpu_pin_o | output | 20 | Five pin outputs per CPU, CPU c at bits c*5+4..c*5 |

## Verification
Source-to-status and source-to-pin paths are combinational. The bench therefore changes `irq_src_i` between edges and samples the pins and the status read 1 ns later, in the same cycle. Register and mailbox writes, and bridge events, are registered at one rising edge. The bench holds each of these stimuli across exactly one edge and checks the result at the following falling edge. The case where an event and a clear land on the same edge is driven on one shared edge, so that the clear-wins outcome is observed in the cycle after it.

// File: rtl/irqmap_pkg.sv
`timescale 1ns/1ps
package irqmap_pkg;
  localparam int DATA_W = 64;
  localparam logic [3:0] OFF_MASK_H     = 4'h0;
  localparam logic [3:0] OFF_MASK_L     = 4'h1;
  localparam logic [3:0] OFF_STAT_H     = 4'h2;
  localparam logic [3:0] OFF_STAT_L     = 4'h3;
  localparam logic [3:0] OFF_MB0_SET    = 4'h4;
  localparam logic [3:0] OFF_MB1_SET    = 4'h5;
  localparam logic [3:0] OFF_MB0_CLR    = 4'h6;
  localparam logic [3:0] OFF_MB1_CLR    = 4'h7;
  localparam logic [3:0] OFF_PEND_H     = 4'h8;
  localparam logic [3:0] OFF_PEND_L     = 4'h9;
  localparam logic [3:0] OFF_PEND_H_CLR = 4'hA;
  localparam logic [3:0] OFF_PEND_L_CLR = 4'hB;
endpackage

// File: rtl/irqmap_pend_latch.sv
`timescale 1ns/1ps
module irqmap_pend_latch #(
  parameter int N_SRC = 128
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] evt_i,
  input  logic [N_SRC-1:0] clr_i,
  output logic [N_SRC-1:0] pend_o
);
  logic [N_SRC-1:0] pend_q;

  // clear has priority over a same-edge event
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q | evt_i) & ~clr_i;
  end

  assign pend_o = pend_q;

  a_r8_clear_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i != '0) |=> ((pend_q & $past(clr_i)) == '0));

  a_r8_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q != '0) |=> ((pend_q & $past(pend_q)) == ($past(pend_q) & ~$past(clr_i))));
endmodule

// File: rtl/irqmap_pin_sel.sv
`timescale 1ns/1ps
module irqmap_pin_sel #(
  parameter int N_SRC = 128,
  parameter int N_PIN = 5,
  parameter int MAP_W = 3
) (
  input  logic [N_SRC-1:0]       stat_i,
  input  logic [N_SRC*MAP_W-1:0] map_i,
  output logic [N_PIN-1:0]       pin_o
);
  always_comb begin
    pin_o = '0;
    for (int k = 0; k < N_PIN; k++) begin
      for (int s = 1; s < N_SRC; s++) begin
        if (stat_i[s] && (map_i[s*MAP_W +: MAP_W] == MAP_W'(k))) pin_o[k] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irqmap_cpu_slice.sv
`timescale 1ns/1ps
module irqmap_cpu_slice
  import irqmap_pkg::*;
#(
  parameter int N_SRC    = 128,
  parameter int N_PIN    = 5,
  parameter int MAP_W    = 3,
  parameter int IDX_W    = 7,
  parameter int MBOX_SRC = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              map_sel_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [N_SRC-1:0]  src_i,
  input  logic [N_SRC-1:0]  pend_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [N_PIN-1:0]  pin_o
);
  localparam int MB_LSB = DATA_W - 16;

  logic [N_SRC-1:0]       mask_q;
  logic [MAP_W-1:0]       map_q [N_SRC];
  logic [DATA_W-1:0]      mb0_q, mb1_q;
  logic [N_SRC-1:0]       raw, stat;
  logic [DATA_W-1:0]      stat_h, stat_l;
  logic [N_SRC*MAP_W-1:0] map_flat;
  logic                   reg_hit;
  logic [3:0]             off;

  assign off     = idx_i[3:0];
  assign reg_hit = !map_sel_i && (idx_i[IDX_W-1:4] == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '1;
      mb0_q  <= '0;
      mb1_q  <= '0;
      for (int s = 0; s < N_SRC; s++) map_q[s] <= '0;
    end else if (we_i) begin
      if (map_sel_i) map_q[idx_i] <= wdata_i[MAP_W-1:0];
      else if (reg_hit) begin
        case (off)
          OFF_MASK_H:  mask_q[DATA_W-1:0]     <= wdata_i;
          OFF_MASK_L:  mask_q[N_SRC-1:DATA_W] <= wdata_i;
          OFF_MB0_SET: mb0_q <= mb0_q | wdata_i;
          OFF_MB1_SET: mb1_q <= mb1_q | wdata_i;
          OFF_MB0_CLR: mb0_q <= mb0_q & ~wdata_i;
          OFF_MB1_CLR: mb1_q <= mb1_q & ~wdata_i;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    raw = src_i | pend_i;
    raw[MBOX_SRC] = raw[MBOX_SRC] | (|mb0_q[DATA_W-1:MB_LSB]);
    raw[0] = 1'b0;  // high bit 0 has no source
  end

  assign stat   = raw & ~mask_q;
  assign stat_l = stat[N_SRC-1:DATA_W];
  assign stat_h = {stat[DATA_W-1:1], |stat_l};

  for (genvar s = 0; s < N_SRC; s++) begin : g_map
    assign map_flat[s*MAP_W +: MAP_W] = map_q[s];
  end

  irqmap_pin_sel #(.N_SRC(N_SRC), .N_PIN(N_PIN), .MAP_W(MAP_W)) u_pin_sel (
    .stat_i (stat),
    .map_i  (map_flat),
    .pin_o  (pin_o)
  );

  always_comb begin
    rdata_o = '0;
    if (map_sel_i) rdata_o[MAP_W-1:0] = map_q[idx_i];
    else if (reg_hit) begin
      case (off)
        OFF_MASK_H:                  rdata_o = mask_q[DATA_W-1:0];
        OFF_MASK_L:                  rdata_o = mask_q[N_SRC-1:DATA_W];
        OFF_STAT_H:                  rdata_o = stat_h;
        OFF_STAT_L:                  rdata_o = stat_l;
        OFF_MB0_SET, OFF_MB0_CLR:    rdata_o = mb0_q;
        OFF_MB1_SET, OFF_MB1_CLR:    rdata_o = mb1_q;
        OFF_PEND_H, OFF_PEND_H_CLR:  rdata_o = pend_i[DATA_W-1:0];
        OFF_PEND_L, OFF_PEND_L_CLR:  rdata_o = pend_i[N_SRC-1:DATA_W];
        default:                     rdata_o = '0;
      endcase
    end
  end

  a_r1_all_masked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&mask_q) |-> (pin_o == '0));

  a_r4_pin_needs_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat == '0) |-> (pin_o == '0));

  a_r6_mbox_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && reg_hit && off == OFF_MB0_CLR) |=> ((mb0_q & $past(wdata_i)) == '0));
endmodule

// File: rtl/irqmap_router.sv
`timescale 1ns/1ps
module irqmap_router
  import irqmap_pkg::*;
#(
  parameter int N_CPU    = 4,
  parameter int N_PIN    = 5,
  parameter int MBOX_SRC = 7
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [2*DATA_W-1:0]    irq_src_i,
  input  logic [2*DATA_W-1:0]    bridge_evt_i,
  input  logic                   reg_we_i,
  input  logic [9:0]             reg_addr_i,
  input  logic [DATA_W-1:0]      reg_wdata_i,
  output logic [DATA_W-1:0]      reg_rdata_o,
  output logic [N_CPU*N_PIN-1:0] cpu_pin_o
);
  localparam int N_SRC  = 2 * DATA_W;
  localparam int IDX_W  = $clog2(N_SRC);
  localparam int CPU_W  = $clog2(N_CPU);
  localparam int ADDR_W = CPU_W + 1 + IDX_W;
  localparam int MAP_W  = $clog2(N_PIN);

  logic [CPU_W-1:0]  cpu_sel;
  logic              map_sel;
  logic [IDX_W-1:0]  idx;
  logic              reg_hit;
  logic [N_SRC-1:0]  pend, pend_clr;
  logic [DATA_W-1:0] slice_rdata [N_CPU];

  assign cpu_sel = reg_addr_i[ADDR_W-1 -: CPU_W];
  assign map_sel = reg_addr_i[IDX_W];
  assign idx     = reg_addr_i[IDX_W-1:0];
  assign reg_hit = reg_we_i && !map_sel && (idx[IDX_W-1:4] == '0);

  always_comb begin
    pend_clr = '0;
    if (reg_hit && idx[3:0] == OFF_PEND_H_CLR) pend_clr[DATA_W-1:0]     = reg_wdata_i;
    if (reg_hit && idx[3:0] == OFF_PEND_L_CLR) pend_clr[N_SRC-1:DATA_W] = reg_wdata_i;
  end

  irqmap_pend_latch #(.N_SRC(N_SRC)) u_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .evt_i  (bridge_evt_i),
    .clr_i  (pend_clr),
    .pend_o (pend)
  );

  for (genvar c = 0; c < N_CPU; c++) begin : g_cpu
    irqmap_cpu_slice #(
      .N_SRC(N_SRC), .N_PIN(N_PIN), .MAP_W(MAP_W), .IDX_W(IDX_W), .MBOX_SRC(MBOX_SRC)
    ) u_slice (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .we_i      (reg_we_i && (cpu_sel == CPU_W'(c))),
      .map_sel_i (map_sel),
      .idx_i     (idx),
      .wdata_i   (reg_wdata_i),
      .src_i     (irq_src_i),
      .pend_i    (pend),
      .rdata_o   (slice_rdata[c]),
      .pin_o     (cpu_pin_o[c*N_PIN +: N_PIN])
    );
  end

  assign reg_rdata_o = slice_rdata[cpu_sel];
endmodule

// File: tb/irqmap_router_bench.sv
`timescale 1ns/1ps
module irqmap_router_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [127:0] src = '0;
  logic [127:0] evt = '0;
  logic         we = 1'b0;
  logic [9:0]   addr = '0;
  logic [63:0]  wdata = '0;
  logic [63:0]  rdata;
  logic [19:0]  pins;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  irqmap_router u_irqmap_router (
    .clk_i(clk), .rst_ni(rst_n), .irq_src_i(src), .bridge_evt_i(evt),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .cpu_pin_o(pins)
  );

  // vector table: cpu, source, pin select, expected pin index
  localparam int NV = 5;
  localparam int V_CPU [NV] = '{0, 1, 2, 3, 0};
  localparam int V_SRC [NV] = '{5, 64, 127, 63, 100};
  localparam int V_PIN [NV] = '{0, 2, 4, 1, 3};
  localparam int V_EXP [NV] = '{0, 7, 14, 16, 3};

  function automatic logic [9:0] ra(int c, int off);
    return {2'(c), 1'b0, 7'(off)};
  endfunction
  function automatic logic [9:0] ma(int c, int s);
    return {2'(c), 1'b1, 7'(s)};
  endfunction

  task automatic wr(input logic [9:0] a, input logic [63:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [63:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [63:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(ra(0, 0), v);   chk("R1 mask high", v, '1);
    rd(ra(3, 1), v);   chk("R1 mask low", v, '1);
    rd(ma(2, 127), v); chk("R1 map entry", v, 64'd0);
    rd(ra(1, 4), v);   chk("R1 mailbox0", v, 64'd0);
    rd(ra(0, 9), v);   chk("R1 latch low", v, 64'd0);
    chk("R1 pins", 64'(pins), 64'd0);

    // R2/R4 table walk
    for (int i = 0; i < NV; i++) begin
      int c, s, b, bank;
      c = V_CPU[i]; s = V_SRC[i]; b = s % 64; bank = (s < 64) ? 0 : 1;
      wr(ma(c, s), 64'(V_PIN[i]));
      wr(ra(c, bank), ~(64'd1 << b));
      src[s] = 1'b1; #1;
      chk("R4 table pin", 64'(pins), 64'd1 << V_EXP[i]);
      rd(ra(c, 2 + bank), v);
      chk("R2 table status", v, 64'd1 << b);
      if (bank == 1) begin
        rd(ra(c, 2), v); chk("R3 summary bit", v, 64'd1);
      end
      src[s] = 1'b0; #1;
      chk("R2 source released", 64'(pins), 64'd0);
      wr(ra(c, bank), '1);
    end

    // R5 writes to CPU1 left CPU0 untouched
    rd(ma(0, 64), v); chk("R5 cpu0 map", v, 64'd0);
    rd(ra(0, 1), v);  chk("R5 cpu0 mask low", v, '1);

    // R3 summary ignores mask bit 0, drives no pin through entry 0
    wr(ma(1, 0), 64'd4);
    wr(ra(1, 1), ~(64'd1 << 6));
    src[70] = 1'b1; #1;
    rd(ra(1, 2), v); chk("R3 summary with bit0 masked", v, 64'd1);
    chk("R3 pin via own entry only", 64'(pins), 64'd1 << 5);
    src[70] = 1'b0;
    wr(ra(1, 1), '1);

    // R4 select values 5..7 drive nothing
    wr(ma(0, 10), 64'hFFFF_FFFF_FFFF_FFFD);
    rd(ma(0, 10), v); chk("R4 entry keeps 3 bits", v, 64'd5);
    wr(ra(0, 0), ~(64'd1 << 10));
    src[10] = 1'b1; #1;
    chk("R4 select 5 no pin", 64'(pins), 64'd0);
    rd(ra(0, 2), v); chk("R2 status with select 5", v, 64'd1 << 10);
    src[10] = 1'b0;
    wr(ra(0, 0), '1);

    // R6 mailbox set / clear aliases
    wr(ra(2, 5), 64'h00F0);
    rd(ra(2, 5), v); chk("R6 set", v, 64'h00F0);
    wr(ra(2, 5), 64'h0F00);
    rd(ra(2, 7), v); chk("R6 set accumulates", v, 64'h0FF0);
    wr(ra(2, 7), 64'h0030);
    rd(ra(2, 5), v); chk("R6 partial clear", v, 64'h0FC0);
    wr(ra(2, 7), '1);
    rd(ra(2, 5), v); chk("R6 clear all", v, 64'd0);

    // R7 mailbox 0 upper bits act as source 7
    wr(ra(2, 0), ~(64'd1 << 7));
    wr(ma(2, 7), 64'd1);
    wr(ra(2, 4), 64'd1 << 50);
    chk("R7 mailbox raises pin", 64'(pins), 64'd1 << 11);
    wr(ra(2, 6), '1);
    chk("R7 cleared mailbox", 64'(pins), 64'd0);
    wr(ra(2, 4), 64'd1 << 3);
    chk("R7 low mailbox bits ignored", 64'(pins), 64'd0);
    wr(ra(2, 6), '1);
    wr(ra(2, 0), '1);

    // R8 bridge latch
    wr(ma(0, 90), 64'd2);
    wr(ra(0, 1), ~(64'd1 << 26));
    @(negedge clk); evt[90] = 1'b1;
    @(negedge clk); evt[90] = 1'b0;
    chk("R8 latched pin", 64'(pins), 64'd1 << 2);
    repeat (3) @(negedge clk);
    rd(ra(3, 9), v); chk("R8 latch sticky", v, 64'd1 << 26);
    wr(ra(3, 11), 64'd1 << 26);
    rd(ra(0, 9), v); chk("R8 cleared from other window", v, 64'd0);
    chk("R8 pin drops", 64'(pins), 64'd0);
    @(negedge clk); evt[90] = 1'b1; we = 1'b1; addr = ra(1, 11); wdata = 64'd1 << 26;
    @(negedge clk); evt[90] = 1'b0; we = 1'b0;
    rd(ra(0, 9), v); chk("R8 clear wins", v, 64'd0);
    wr(ra(0, 1), '1);

    // R9 map edges
    rd(ra(0, 15), v); chk("R9 unused offset", v, 64'd0);
    wr(ra(0, 2), '1);
    rd(ra(0, 2), v); chk("R9 status write ignored", v, 64'd0);
    wr(ra(0, 8), '1);
    rd(ra(0, 8), v); chk("R9 latch write ignored", v, 64'd0);

    finish_run();
  end
endmodule